// File: doc/BRIEF.md
# Latched Fault Protection Supervisor

This block sits beside the switching control of an offline power converter and decides whether the power switch may run. Analog comparators and timers elsewhere report five kinds of trouble: excessive primary current, output over-voltage, a shorted output, low input line and an overheated die. The supervisor turns each report into a protection action. Some faults stop switching in the same cycle they are seen. Others must persist for a qualification window before they count. Every action ends in either a latch or a self-clearing hold.

Over-current, over-voltage, short-circuit and over-temperature are latched. They can only be cleared by a full supply undervoltage cycle: the supply must drop below its lower threshold and then climb back above its upper threshold. Over-temperature also needs the die to cool before switching resumes. Low input line is not latched; switching comes back by itself once the input recovers. A fault code output reports the first latched fault and holds it until the supply-cycle reset.

Short-circuit detection counts how long the output feedback stays low while switching cycles are launched by the fallback start timer rather than by valley detection. The window is much longer during start-up. Start-up lasts until the feedback first reports a normal output level.

Top module: `fault_supervisor`

## Requirements
- R1: After reset `sw_en` is 0 and `fault_code` is 0. Switching is enabled (`sw_en`=1) one clock after `vcc_above_hi` is sampled, provided no fault is active.
- R2: `ocp_trip` forces `sw_en` to 0 in the same cycle. While powered, it latches `fault_code`=1 at the next clock edge.
- R3: `ovp_trip` forces `sw_en` to 0 in the same cycle. While powered, it latches `fault_code`=2 at the next clock edge.
- R4: After start-up, a short circuit latches `fault_code`=3 on the SCP_CYC-th consecutive clock edge at which `fb_short_low` is 1 and the last started cycle was timer-launched. One edge fewer latches nothing.
- R5: While start-up is in progress, the short-circuit window is SCP_START_CYC edges instead of SCP_CYC. Start-up runs from power-up until `fb_normal` is first sampled high.
- R6: A cycle started with `cycle_start`=1 and `cycle_by_timer`=0 (valley-launched) clears the short-circuit count, so a new full window is needed.
- R7: `in_below_bo` held for BO_CYC consecutive edges drops `sw_en` without changing `fault_code`. `in_above_bi` releases the hold, and any interruption of the low input restarts the count.
- R8: `temp_hot` forces `sw_en` to 0 at once and latches `fault_code`=4 while powered. Switching resumes only after both `temp_cool` and a supply cycle, in either order.
- R9: A latched fault keeps `sw_en` at 0. It is cleared only by `vcc_below_lo` followed by `vcc_above_hi`. `vcc_below_lo` alone clears `fault_code` to 0 and leaves `sw_en` at 0.
- R10: `fault_code` holds the first latched fault while later faults arrive. Faults latched on the same edge are ranked over-current (1), over-voltage (2), short-circuit (3), over-temperature (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ocp_trip | input | 1 | Sense voltage above over-current level |
| ovp_trip | input | 1 | Feedback above over-voltage level |
| fb_short_low | input | 1 | Feedback below short-circuit level |
| fb_normal | input | 1 | Feedback reached normal level (ends start-up) |
| cycle_start | input | 1 | A switching cycle starts this clock |
| cycle_by_timer | input | 1 | Qualifies cycle_start: 1 = start timer, 0 = valley |
| in_below_bo | input | 1 | Input peak below brownout threshold |
| in_above_bi | input | 1 | Input peak above brown-in threshold |
| temp_hot | input | 1 | Die above shutdown temperature |
| temp_cool | input | 1 | Die cooled below recovery temperature |
| vcc_above_hi | input | 1 | Supply above upper undervoltage threshold |
| vcc_below_lo | input | 1 | Supply below lower undervoltage threshold |
| sw_en | output | 1 | Switching permitted |
| fault_code | output | 3 | First latched fault: 0 none, 1 OCP, 2 OVP, 3 short, 4 thermal |

## Verification
The bench targets the exact edges of the short-circuit and brownout windows. A window that is off by one would latch or drop switching one cycle early or late. It also checks that a valley-launched cycle restarts the short-circuit count; a design that only paused the count would trip early. Thermal recovery is tested in both orders, cooling then supply cycle and supply cycle then cooling. A design that let either event alone release the fault would re-enable switching too soon. Simultaneous faults and faults that arrive after a latch check that the code keeps the first fault and follows the stated ranking.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_OVERCUR  = 3'd1,
        FC_OVERVOLT = 3'd2,
        FC_SHORT    = 3'd3,
        FC_THERMAL  = 3'd4
    } fault_code_e;

    typedef struct packed {
        logic thermal;
        logic short_ckt;
        logic overvolt;
        logic overcur;
    } fault_ev_t;

    function automatic fault_code_e pick_first(fault_ev_t ev);
        if (ev.overcur)        return FC_OVERCUR;
        else if (ev.overvolt)  return FC_OVERVOLT;
        else if (ev.short_ckt) return FC_SHORT;
        else if (ev.thermal)   return FC_THERMAL;
        return FC_NONE;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsup_supply.sv
module fsup_supply (
    input  logic clk,
    input  logic rst,
    input  logic vcc_above_hi,
    input  logic vcc_below_lo,
    input  logic fb_normal,
    output logic powered,
    output logic startup
);
    always_ff @(posedge clk) begin
        if (rst || vcc_below_lo) begin
            powered <= 1'b0;
            startup <= 1'b0;
        end else begin
            if (vcc_above_hi)
                powered <= 1'b1;
            if (!powered && vcc_above_hi)
                startup <= 1'b1;
            else if (fb_normal)
                startup <= 1'b0;
        end
    end
endmodule

// File: rtl/fsup_qual_timer.sv
module fsup_qual_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         cond,
    input  logic [W-1:0] limit,
    output logic         trip
);
    logic [W-1:0] cnt;
    logic         at_lim;

    assign at_lim = (cnt >= limit - W'(1));
    assign trip   = cond && at_lim;

    always_ff @(posedge clk) begin
        if (rst || clr || !cond)
            cnt <= '0;
        else if (!at_lim)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/fsup_first_fault.sv
module fsup_first_fault
    import fsup_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  fault_ev_t   ev,
    output fault_code_e code
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            code <= FC_NONE;
        else if (en && code == FC_NONE && (|ev))
            code <= pick_first(ev);
    end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int SCP_CYC       = 575000,
    parameter int SCP_START_CYC = 25000000,
    parameter int BO_CYC        = 6000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ocp_trip,
    input  logic       ovp_trip,
    input  logic       fb_short_low,
    input  logic       fb_normal,
    input  logic       cycle_start,
    input  logic       cycle_by_timer,
    input  logic       in_below_bo,
    input  logic       in_above_bi,
    input  logic       temp_hot,
    input  logic       temp_cool,
    input  logic       vcc_above_hi,
    input  logic       vcc_below_lo,
    output logic       sw_en,
    output logic [2:0] fault_code
);
    localparam int SCP_W = $clog2(max2(SCP_CYC, SCP_START_CYC) + 1);
    localparam int BO_W  = $clog2(BO_CYC + 1);

    logic        powered, startup;
    logic        timer_mode, bo_active, therm_hold;
    logic        scp_cond, scp_trip, bo_cond, bo_trip;
    logic [SCP_W-1:0] scp_limit;
    fault_ev_t   ev;
    fault_code_e code;

    fsup_supply u_supply (
        .clk(clk), .rst(rst),
        .vcc_above_hi(vcc_above_hi), .vcc_below_lo(vcc_below_lo),
        .fb_normal(fb_normal),
        .powered(powered), .startup(startup)
    );

    // Launch source of the most recent switching cycle
    always_ff @(posedge clk) begin
        if (rst || vcc_below_lo)
            timer_mode <= 1'b0;
        else if (cycle_start)
            timer_mode <= cycle_by_timer;
    end

    assign scp_limit = startup ? SCP_W'(SCP_START_CYC) : SCP_W'(SCP_CYC);
    assign scp_cond  = powered && (code == FC_NONE) && fb_short_low && timer_mode;

    fsup_qual_timer #(.W(SCP_W)) u_scp_timer (
        .clk(clk), .rst(rst), .clr(vcc_below_lo),
        .cond(scp_cond), .limit(scp_limit), .trip(scp_trip)
    );

    assign bo_cond = powered && in_below_bo && !bo_active;

    fsup_qual_timer #(.W(BO_W)) u_bo_timer (
        .clk(clk), .rst(rst), .clr(vcc_below_lo),
        .cond(bo_cond), .limit(BO_W'(BO_CYC)), .trip(bo_trip)
    );

    // Brownout: self-releasing hold
    always_ff @(posedge clk) begin
        if (rst || vcc_below_lo)
            bo_active <= 1'b0;
        else if (bo_trip)
            bo_active <= 1'b1;
        else if (in_above_bi)
            bo_active <= 1'b0;
    end

    // Thermal hold survives supply cycles; only cooling releases it
    always_ff @(posedge clk) begin
        if (rst)
            therm_hold <= 1'b0;
        else if (temp_hot)
            therm_hold <= 1'b1;
        else if (temp_cool)
            therm_hold <= 1'b0;
    end

    always_comb begin
        ev.overcur   = ocp_trip;
        ev.overvolt  = ovp_trip;
        ev.short_ckt = scp_trip;
        ev.thermal   = temp_hot;
    end

    fsup_first_fault u_latch (
        .clk(clk), .rst(rst), .clr(vcc_below_lo),
        .en(powered), .ev(ev), .code(code)
    );

    assign fault_code = code;
    assign sw_en = powered && (code == FC_NONE) && !bo_active && !therm_hold
                   && !ocp_trip && !ovp_trip && !temp_hot;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
    input logic       clk,
    input logic       rst,
    input logic       ocp_trip,
    input logic       ovp_trip,
    input logic       temp_hot,
    input logic       vcc_below_lo,
    input logic       powered,
    input logic       sw_en,
    input logic [2:0] fault_code
);
    a_r2_ocp_blocks: assert property (@(posedge clk) disable iff (rst)
        ocp_trip |-> !sw_en);

    a_r2_ocp_latches: assert property (@(posedge clk) disable iff (rst)
        (powered && ocp_trip && !vcc_below_lo) |=> (fault_code != 3'd0));

    a_r3_ovp_blocks: assert property (@(posedge clk) disable iff (rst)
        ovp_trip |-> !sw_en);

    a_r8_hot_blocks: assert property (@(posedge clk) disable iff (rst)
        temp_hot |-> !sw_en);

    a_r9_latch_blocks: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0) |-> !sw_en);

    a_r9_low_supply_clears: assert property (@(posedge clk) disable iff (rst)
        vcc_below_lo |=> (!sw_en && fault_code == 3'd0));

    a_r10_code_held: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0 && !vcc_below_lo) |=> $stable(fault_code));
endmodule

bind fault_supervisor fsup_checker u_fsup_checker (
    .clk(clk), .rst(rst),
    .ocp_trip(ocp_trip), .ovp_trip(ovp_trip), .temp_hot(temp_hot),
    .vcc_below_lo(vcc_below_lo), .powered(powered),
    .sw_en(sw_en), .fault_code(fault_code)
);

// File: tb/tb_fault_supervisor.sv
module tb_fault_supervisor;
    localparam int N_SCP = 20;
    localparam int N_ST  = 60;
    localparam int N_BO  = 30;

    logic clk = 1'b0;
    logic rst;
    logic ocp_trip, ovp_trip, fb_short_low, fb_normal, cycle_start, cycle_by_timer;
    logic in_below_bo, in_above_bi, temp_hot, temp_cool, vcc_above_hi, vcc_below_lo;
    logic sw_en;
    logic [2:0] fault_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fault_supervisor #(.SCP_CYC(N_SCP), .SCP_START_CYC(N_ST), .BO_CYC(N_BO)) dut (
        .clk(clk), .rst(rst),
        .ocp_trip(ocp_trip), .ovp_trip(ovp_trip),
        .fb_short_low(fb_short_low), .fb_normal(fb_normal),
        .cycle_start(cycle_start), .cycle_by_timer(cycle_by_timer),
        .in_below_bo(in_below_bo), .in_above_bi(in_above_bi),
        .temp_hot(temp_hot), .temp_cool(temp_cool),
        .vcc_above_hi(vcc_above_hi), .vcc_below_lo(vcc_below_lo),
        .sw_en(sw_en), .fault_code(fault_code)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic zero_inputs();
        ocp_trip = 0; ovp_trip = 0; fb_short_low = 0; fb_normal = 0;
        cycle_start = 0; cycle_by_timer = 0; in_below_bo = 0; in_above_bi = 0;
        temp_hot = 0; temp_cool = 0; vcc_above_hi = 0; vcc_below_lo = 0;
    endtask

    task automatic power_cycle();
        vcc_below_lo = 1; tick();
        vcc_below_lo = 0; vcc_above_hi = 1; tick();
        vcc_above_hi = 0;
    endtask

    task automatic end_startup();
        fb_normal = 1; tick(); fb_normal = 0;
    endtask

    task automatic timer_cycle();
        cycle_start = 1; cycle_by_timer = 1; tick();
        cycle_start = 0; cycle_by_timer = 0;
    endtask

    // ---------------- reference model for the random phase ----------------
    bit m_pow, m_start, m_tmode, m_bo, m_hold;
    int m_code, m_scpc, m_boc;

    function automatic int first_of(bit oc, bit ov, bit sc, bit th);
        if (oc) return 1;
        if (ov) return 2;
        if (sc) return 3;
        if (th) return 4;
        return 0;
    endfunction

    function automatic bit exp_en();
        return m_pow && m_code == 0 && !m_bo && !m_hold && !ocp_trip && !ovp_trip && !temp_hot;
    endfunction

    task automatic model_next();
        int lim;
        bit scond, strip, bcond, btrip;
        if (temp_hot) m_hold = 1; else if (temp_cool) m_hold = 0;
        if (vcc_below_lo) begin
            m_pow = 0; m_start = 0; m_tmode = 0; m_code = 0;
            m_scpc = 0; m_boc = 0; m_bo = 0;
        end else begin
            lim   = m_start ? N_ST : N_SCP;
            scond = m_pow && m_code == 0 && fb_short_low && m_tmode;
            strip = scond && (m_scpc >= lim - 1);
            bcond = m_pow && in_below_bo && !m_bo;
            btrip = bcond && (m_boc >= N_BO - 1);
            if (m_pow && m_code == 0)
                m_code = first_of(ocp_trip, ovp_trip, strip, temp_hot);
            m_scpc = !scond ? 0 : (m_scpc >= lim - 1 ? m_scpc : m_scpc + 1);
            m_boc  = !bcond ? 0 : (m_boc >= N_BO - 1 ? m_boc : m_boc + 1);
            if (btrip) m_bo = 1; else if (in_above_bi) m_bo = 0;
            if (cycle_start) m_tmode = cycle_by_timer;
            if (!m_pow && vcc_above_hi) m_start = 1; else if (fb_normal) m_start = 0;
            if (vcc_above_hi) m_pow = 1;
        end
    endtask

    function automatic bit chance(int n);
        return ($urandom % n) == 0;
    endfunction

    initial begin
        #600000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        zero_inputs();
        rst = 1;
        tick(3);
        rst = 0;
        tick();
        // R1 reset state
        check("R1 sw_en after reset", sw_en, 0);
        check("R1 code after reset", fault_code, 0);
        vcc_above_hi = 1; tick(); vcc_above_hi = 0;
        check("R1 sw_en after power-up", sw_en, 1);
        end_startup();

        // R2 over-current
        ocp_trip = 1; #1;
        check("R2 ocp immediate block", sw_en, 0);
        tick(); ocp_trip = 0; #1;
        check("R2 ocp code", fault_code, 1);
        check("R2 ocp stays off", sw_en, 0);
        ovp_trip = 1; tick(); ovp_trip = 0; temp_hot = 0;
        check("R10 first fault kept", fault_code, 1);

        // R9 supply-cycle clear
        vcc_below_lo = 1; tick(); vcc_below_lo = 0;
        check("R9 code cleared by low supply", fault_code, 0);
        check("R9 still off before upper threshold", sw_en, 0);
        vcc_above_hi = 1; tick(); vcc_above_hi = 0;
        check("R9 resumes after supply cycle", sw_en, 1);
        end_startup();

        // R10 simultaneous ranking, R3 over-voltage
        ocp_trip = 1; ovp_trip = 1; tick(); ocp_trip = 0; ovp_trip = 0;
        check("R10 ocp outranks ovp", fault_code, 1);
        power_cycle(); end_startup();
        ovp_trip = 1; #1;
        check("R3 ovp immediate block", sw_en, 0);
        tick(); ovp_trip = 0;
        check("R3 ovp code", fault_code, 2);
        power_cycle(); end_startup();

        // R4 short-circuit window after start-up
        fb_short_low = 1; timer_cycle();
        tick(N_SCP - 1);
        check("R4 no trip one edge early", fault_code, 0);
        check("R4 still switching", sw_en, 1);
        tick();
        check("R4 short latched", fault_code, 3);
        check("R4 switching stopped", sw_en, 0);
        fb_short_low = 0; power_cycle(); end_startup();

        // R6 valley cycle restarts count
        fb_short_low = 1; timer_cycle();
        tick(N_SCP - 2);
        cycle_start = 1; cycle_by_timer = 0; tick(); cycle_start = 0;
        timer_cycle();
        tick(N_SCP - 1);
        check("R6 count restarted by valley", fault_code, 0);
        tick();
        check("R6 full window after restart", fault_code, 3);
        fb_short_low = 0; power_cycle();

        // R5 start-up window (start-up not ended)
        fb_short_low = 1; timer_cycle();
        tick(N_SCP);
        check("R5 normal window ignored in start-up", fault_code, 0);
        tick(N_ST - 1 - N_SCP);
        check("R5 no trip one edge early", fault_code, 0);
        tick();
        check("R5 start-up window trip", fault_code, 3);
        fb_short_low = 0; power_cycle(); end_startup();

        // R7 brownout
        in_below_bo = 1; tick(N_BO - 1);
        in_below_bo = 0; tick();
        in_below_bo = 1; tick(N_BO - 1);
        check("R7 interrupted count restarts", sw_en, 1);
        tick();
        check("R7 brownout stops switching", sw_en, 0);
        check("R7 brownout not latched", fault_code, 0);
        in_below_bo = 0; in_above_bi = 1; tick(); in_above_bi = 0;
        check("R7 released by brown-in", sw_en, 1);

        // R8 thermal: supply cycle first, then cooling
        temp_hot = 1; #1;
        check("R8 hot immediate block", sw_en, 0);
        tick(); temp_hot = 0;
        check("R8 thermal code", fault_code, 4);
        power_cycle();
        check("R8 supply cycle alone not enough", sw_en, 0);
        temp_cool = 1; tick(); temp_cool = 0;
        check("R8 resumes after cool", sw_en, 1);
        // cooling first, then supply cycle
        temp_hot = 1; tick(); temp_hot = 0;
        temp_cool = 1; tick(); temp_cool = 0;
        check("R8 cooling alone not enough", sw_en, 0);
        power_cycle();
        check("R8 resumes after supply cycle", sw_en, 1);

        // Random phase against the reference model
        zero_inputs();
        rst = 1; tick(2); rst = 0;
        m_pow = 0; m_start = 0; m_tmode = 0; m_bo = 0; m_hold = 0;
        m_code = 0; m_scpc = 0; m_boc = 0;
        for (int i = 0; i < 6000; i++) begin
            ocp_trip     = chance(400);
            ovp_trip     = chance(400);
            temp_hot     = chance(600);
            temp_cool    = chance(25);
            vcc_below_lo = chance(300);
            vcc_above_hi = chance(8);
            if (chance(40)) fb_short_low = ~fb_short_low;
            if (chance(50)) in_below_bo  = ~in_below_bo;
            in_above_bi  = chance(30);
            fb_normal    = chance(100);
            cycle_start  = chance(5);
            cycle_by_timer = !chance(4);
            #1;
            check("R9 random sw_en", sw_en, exp_en());
            check("R10 random fault_code", fault_code, m_code);
            model_next();
            tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule